// File: doc/BRIEF.md
# Two-Channel Address Breakpoint Comparator

This block sits beside a processor bus and watches every bus cycle that is strobed as valid. Each of two independent channels holds a breakpoint address and a control byte. The control byte says which kind of cycle may hit: instruction fetch, data read, data write, or either data access. It also sets how many low address bits are ignored, and whether cycles owned by the transfer controller count as well as cycles owned by the CPU. When a cycle meets every programmed condition, the channel's sticky hit flag is set. If that channel's interrupt enable is on, the combined interrupt request is raised.

Software reaches the registers through a plain read/write port. A hit flag can only be cleared by a two-step handshake: software must first read the control byte while the flag is 1, and then write 0 to the flag. The block only signals a break. Stopping the processor and the exception handling that follows belong elsewhere.

Top module: `brk_cmp_top`

## Requirements
- R1: After reset, both control bytes and both breakpoint addresses read as 0, both hit flags are 0 and `irq_o` is 0.
- R2: Register map on `reg_addr`: 0 is the channel A control byte, 1 is the channel A address, 2 is the channel B control byte, 3 is the channel B address. Reads return the value on `reg_rdata` in the same cycle, zero-extended. Control byte layout: bit 7 is the hit flag, bit 6 is the master select, bits 5:3 are the mask code, bits 2:1 are the cycle select, and bit 0 is the interrupt enable.
- R3: The mask code sets how many low address bits are excluded from the compare: 000 excludes none, 001 excludes 1, 010 excludes 2, 011 excludes 3, 100 excludes 4, 101 excludes 8, 110 excludes 12, and 111 excludes 16. A difference in any compared bit prevents a hit.
- R4: The cycle select allows hits as follows: 00 on fetch only, 01 on read only, 10 on write only, 11 on read or write. The encoding of `bus_kind` is 00 for fetch, 01 for read and 10 for write.
- R5: With master select 0, only cycles where `bus_dma` is 0 can hit. With master select 1, cycles hit whichever master owns the bus.
- R6: A matching cycle with `bus_valid` high sets the hit flag at the next clock edge. A matching address presented without `bus_valid` sets nothing.
- R7: Writing 1 to the hit flag leaves it unchanged. Writing 0 to the flag without a read of it as 1 since the last clear also leaves it set.
- R8: After a read of the control byte returns the flag as 1, a write of 0 to bit 7 clears the flag. The other control bits take the written value.
- R9: If a hit and a clearing write fall in the same cycle, the flag stays 1. That write still uses up the read qualification, so a further 0 write without a new read does not clear the flag.
- R10: `irq_o` is 1 exactly when some channel has both its flag and its interrupt enable set. With the enable at 0 the flag still sets.
- R11: The channels are independent. A hit on one channel's conditions does not set the other channel's flag, and register writes to one channel do not change the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (arms flag clearing) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational |
| bus_valid | input | 1 | One bus cycle is present this clock |
| bus_addr | input | 24 | Bus cycle address |
| bus_kind | input | 2 | Cycle kind: 00 fetch, 01 read, 10 write |
| bus_dma | input | 1 | 1 when the transfer controller owns the bus |
| flag_o | output | 2 | Per-channel hit flags (bit 0 = A) |
| irq_o | output | 1 | Combined break interrupt request |

## Verification
Two of the block's functions can fall in the same cycle: a bus cycle that hits, and the software write that clears the flag. The bench arms the clear by reading the control byte with the flag at 1. It then drives, in one clock, a 0 write to bit 7 together with a matching valid bus cycle. The flag must read 1 afterwards. A second 0 write with no fresh read must also leave it at 1, which shows that the qualification was used up while the hit took priority.

// File: rtl/brk_pkg.sv
package brk_pkg;

   typedef enum logic [1:0] {
      KIND_FETCH = 2'b00,
      KIND_READ  = 2'b01,
      KIND_WRITE = 2'b10,
      KIND_NONE  = 2'b11
   } bus_kind_e;

   typedef struct packed {
      logic       flag;
      logic       any_master;
      logic [2:0] mcode;
      logic [1:0] csel;
      logic       ie;
   } brk_ctrl_t;

   localparam int CTRL_W = $bits(brk_ctrl_t);

   function automatic int ignored_bits(input logic [2:0] code);
      case (code)
         3'd0:    return 0;
         3'd1:    return 1;
         3'd2:    return 2;
         3'd3:    return 3;
         3'd4:    return 4;
         3'd5:    return 8;
         3'd6:    return 12;
         default: return 16;
      endcase
   endfunction

endpackage

// File: rtl/brk_mask_gen.sv
module brk_mask_gen #(
   parameter int ADDR_W = 24
) (
   input  logic [2:0]        mcode,
   output logic [ADDR_W-1:0] keep
);
   import brk_pkg::*;

   if (ADDR_W < 16) begin : g_bad_width
      $error("brk_mask_gen: ADDR_W must cover the widest mask (16 bits)");
   end

   always_comb begin
      keep = {ADDR_W{1'b1}} << ignored_bits(mcode);
   end

endmodule

// File: rtl/brk_channel.sv
module brk_channel #(
   parameter int ADDR_W = 24,
   parameter int DATA_W = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_ctrl,
   input  logic                  wr_addr,
   input  logic                  rd_ctrl,
   input  logic [DATA_W-1:0]     wdata,
   input  logic                  bus_valid,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic [1:0]            bus_kind,
   input  logic                  bus_dma,
   output brk_pkg::brk_ctrl_t    ctrl_q,
   output logic [ADDR_W-1:0]     addr_q
);
   import brk_pkg::*;

   logic [ADDR_W-1:0] keep;
   logic              kind_ok;
   logic              master_ok;
   logic              addr_ok;
   logic              hit;
   logic              qual_q;
   logic              clr_req;
   brk_ctrl_t         wr_val;

   brk_mask_gen #(.ADDR_W(ADDR_W)) i_mask (
      .mcode (ctrl_q.mcode),
      .keep  (keep)
   );

   always_comb begin
      case (ctrl_q.csel)
         2'b00:   kind_ok = (bus_kind_e'(bus_kind) == KIND_FETCH);
         2'b01:   kind_ok = (bus_kind_e'(bus_kind) == KIND_READ);
         2'b10:   kind_ok = (bus_kind_e'(bus_kind) == KIND_WRITE);
         default: kind_ok = (bus_kind_e'(bus_kind) == KIND_READ) ||
                            (bus_kind_e'(bus_kind) == KIND_WRITE);
      endcase
   end

   assign master_ok = ctrl_q.any_master | ~bus_dma;
   assign addr_ok   = (((bus_addr ^ addr_q) & keep) == '0);
   assign hit       = bus_valid & kind_ok & master_ok & addr_ok;
   assign wr_val    = brk_ctrl_t'(wdata[CTRL_W-1:0]);
   assign clr_req   = wr_ctrl & ~wr_val.flag & qual_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         addr_q <= '0;
         qual_q <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            ctrl_q.any_master <= wr_val.any_master;
            ctrl_q.mcode      <= wr_val.mcode;
            ctrl_q.csel       <= wr_val.csel;
            ctrl_q.ie         <= wr_val.ie;
         end
         if (wr_addr) begin
            addr_q <= wdata[ADDR_W-1:0];
         end
         ctrl_q.flag <= hit | (ctrl_q.flag & ~clr_req);
         qual_q      <= (rd_ctrl & ctrl_q.flag) | (qual_q & ~clr_req);
      end
   end

   p_hit_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> ctrl_q.flag);

   p_rise_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctrl_q.flag) |-> $past(bus_valid));

   p_write1_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q.flag && wr_ctrl && wdata[CTRL_W-1] |=> ctrl_q.flag);

   p_unread_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q.flag && !qual_q |=> ctrl_q.flag);

   p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      hit && wr_ctrl && !wdata[CTRL_W-1] |=> ctrl_q.flag);

endmodule

// File: rtl/brk_cmp_top.sv
module brk_cmp_top #(
   parameter int NCH    = 2,
   parameter int ADDR_W = 24,
   parameter int DATA_W = 32,
   localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1,
   localparam int RA_W  = CH_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [RA_W-1:0]   reg_addr,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              bus_valid,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [1:0]        bus_kind,
   input  logic              bus_dma,
   output logic [NCH-1:0]    flag_o,
   output logic              irq_o
);
   import brk_pkg::*;

   if (DATA_W < ADDR_W || DATA_W < CTRL_W) begin : g_bad_data
      $error("brk_cmp_top: DATA_W must hold an address and a control byte");
   end
   if (NCH < 1) begin : g_bad_nch
      $error("brk_cmp_top: at least one channel is required");
   end

   brk_ctrl_t         ctrl_q [NCH];
   logic [ADDR_W-1:0] addr_q [NCH];
   logic [NCH-1:0]    irq_vec;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic sel;
      assign sel = (reg_addr[RA_W-1:1] == CH_W'(c));

      brk_channel #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_ch (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_ctrl   (reg_wr & sel & ~reg_addr[0]),
         .wr_addr   (reg_wr & sel &  reg_addr[0]),
         .rd_ctrl   (reg_rd & sel & ~reg_addr[0]),
         .wdata     (reg_wdata),
         .bus_valid (bus_valid),
         .bus_addr  (bus_addr),
         .bus_kind  (bus_kind),
         .bus_dma   (bus_dma),
         .ctrl_q    (ctrl_q[c]),
         .addr_q    (addr_q[c])
      );

      assign flag_o[c]  = ctrl_q[c].flag;
      assign irq_vec[c] = ctrl_q[c].flag & ctrl_q[c].ie;
   end

   assign irq_o = |irq_vec;

   always_comb begin
      reg_rdata = '0;
      for (int c = 0; c < NCH; c++) begin
         if (reg_addr[RA_W-1:1] == CH_W'(c)) begin
            if (reg_addr[0]) reg_rdata = DATA_W'(addr_q[c]);
            else             reg_rdata = DATA_W'(ctrl_q[c]);
         end
      end
   end

   p_irq_needs_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (flag_o != '0));

   p_irq_from_enabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> $past(bus_valid) || $past(reg_wr));

endmodule

// File: tb/test_brk_cmp_top.sv
module test_brk_cmp_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        bus_valid = 1'b0;
   logic [23:0] bus_addr = '0;
   logic [1:0]  bus_kind = '0;
   logic        bus_dma = 1'b0;
   logic [1:0]  flag_o;
   logic        irq_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   brk_cmp_top i_brk_cmp_top (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_addr  (reg_addr),
      .reg_wr    (reg_wr),
      .reg_rd    (reg_rd),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .bus_valid (bus_valid),
      .bus_addr  (bus_addr),
      .bus_kind  (bus_kind),
      .bus_dma   (bus_dma),
      .flag_o    (flag_o),
      .irq_o     (irq_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] cbyte(input logic ms, input logic [2:0] mc,
                                         input logic [1:0] cs, input logic ie);
      return {24'b0, 1'b0, ms, mc, cs, ie};
   endfunction

   task automatic wreg(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rreg(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic bus(input logic [23:0] a, input logic [1:0] k, input logic dma);
      @(negedge clk);
      bus_addr = a; bus_kind = k; bus_dma = dma; bus_valid = 1'b1;
      @(negedge clk);
      bus_valid = 1'b0;
   endtask

   task automatic clear_ch(input int ch);
      logic [31:0] v;
      rreg(2'(2*ch), v);
      wreg(2'(2*ch), {24'b0, 1'b0, v[6:0]});
   endtask

   task automatic t_reset();
      logic [31:0] v;
      for (int a = 0; a < 4; a++) begin
         rreg(2'(a), v);
         chk("R1 register reset", v, 32'h0);
      end
      chk("R1 flags reset", {30'b0, flag_o}, 32'h0);
      chk("R1 irq reset", {31'b0, irq_o}, 32'h0);
   endtask

   task automatic t_regmap();
      logic [31:0] v;
      wreg(2'd1, 32'h00ABCDEF);
      wreg(2'd0, cbyte(1'b1, 3'd5, 2'b10, 1'b1));
      rreg(2'd1, v);
      chk("R2 address readback", v, 32'h00ABCDEF);
      rreg(2'd0, v);
      chk("R2 control readback", v, 32'h0000006D);
      wreg(2'd0, 32'h0);
      wreg(2'd1, 32'h0);
   endtask

   task automatic t_mask();
      int n;
      logic [23:0] base;
      base = 24'hA5C3E7;
      wreg(2'd1, {8'b0, base});
      for (int code = 0; code < 8; code++) begin
         case (code)
            0: n = 0; 1: n = 1; 2: n = 2; 3: n = 3;
            4: n = 4; 5: n = 8; 6: n = 12; default: n = 16;
         endcase
         wreg(2'd0, cbyte(1'b0, 3'(code), 2'b01, 1'b0));
         bus(base, 2'b01, 1'b0);
         chk("R3 exact address hits", {31'b0, flag_o[0]}, 32'h1);
         clear_ch(0);
         if (n > 0) begin
            bus(base ^ (24'h1 << (n - 1)), 2'b01, 1'b0);
            chk("R3 highest ignored bit hits", {31'b0, flag_o[0]}, 32'h1);
            clear_ch(0);
         end
         bus(base ^ (24'h1 << n), 2'b01, 1'b0);
         chk("R3 lowest compared bit misses", {31'b0, flag_o[0]}, 32'h0);
      end
   endtask

   task automatic t_cycle();
      logic exp;
      wreg(2'd1, 32'h00001000);
      for (int sel = 0; sel < 4; sel++) begin
         wreg(2'd0, cbyte(1'b0, 3'd0, 2'(sel), 1'b0));
         for (int k = 0; k < 3; k++) begin
            case (sel)
               0: exp = (k == 0);
               1: exp = (k == 1);
               2: exp = (k == 2);
               default: exp = (k == 1) || (k == 2);
            endcase
            bus(24'h001000, 2'(k), 1'b0);
            chk("R4 cycle select", {31'b0, flag_o[0]}, {31'b0, exp});
            if (flag_o[0]) clear_ch(0);
         end
      end
   endtask

   task automatic t_master();
      wreg(2'd1, 32'h00002000);
      wreg(2'd0, cbyte(1'b0, 3'd0, 2'b00, 1'b0));
      bus(24'h002000, 2'b00, 1'b1);
      chk("R5 dma cycle ignored when cpu only", {31'b0, flag_o[0]}, 32'h0);
      bus(24'h002000, 2'b00, 1'b0);
      chk("R5 cpu cycle hits", {31'b0, flag_o[0]}, 32'h1);
      clear_ch(0);
      wreg(2'd0, cbyte(1'b1, 3'd0, 2'b00, 1'b0));
      bus(24'h002000, 2'b00, 1'b1);
      chk("R5 dma cycle hits when any master", {31'b0, flag_o[0]}, 32'h1);
      clear_ch(0);
   endtask

   task automatic t_flag();
      logic [31:0] v;
      wreg(2'd1, 32'h00003000);
      wreg(2'd0, cbyte(1'b0, 3'd0, 2'b10, 1'b0));
      @(negedge clk);
      bus_addr = 24'h003000; bus_kind = 2'b10; bus_dma = 1'b0; bus_valid = 1'b0;
      @(negedge clk);
      chk("R6 no valid strobe no hit", {31'b0, flag_o[0]}, 32'h0);
      bus(24'h003000, 2'b10, 1'b0);
      chk("R6 flag sets after strobe", {31'b0, flag_o[0]}, 32'h1);
      chk("R10 ie=0 no irq", {31'b0, irq_o}, 32'h0);
      wreg(2'd0, cbyte(1'b0, 3'd0, 2'b10, 1'b1) | 32'h80);
      chk("R7 write 1 keeps flag", {31'b0, flag_o[0]}, 32'h1);
      chk("R10 irq with ie and flag", {31'b0, irq_o}, 32'h1);
      wreg(2'd0, cbyte(1'b0, 3'd0, 2'b10, 1'b1));
      chk("R7 write 0 without read keeps flag", {31'b0, flag_o[0]}, 32'h1);
      rreg(2'd0, v);
      chk("R8 read shows flag", {31'b0, v[7]}, 32'h1);
      wreg(2'd0, cbyte(1'b0, 3'd2, 2'b10, 1'b1));
      chk("R8 clear after read", {31'b0, flag_o[0]}, 32'h0);
      chk("R10 irq drops", {31'b0, irq_o}, 32'h0);
      rreg(2'd0, v);
      chk("R8 other bits written", v, cbyte(1'b0, 3'd2, 2'b10, 1'b1));
   endtask

   task automatic t_priority();
      logic [31:0] v;
      wreg(2'd1, 32'h00004000);
      wreg(2'd0, cbyte(1'b0, 3'd0, 2'b01, 1'b0));
      bus(24'h004000, 2'b01, 1'b0);
      rreg(2'd0, v);
      @(negedge clk);
      reg_addr = 2'd0; reg_wdata = cbyte(1'b0, 3'd0, 2'b01, 1'b0); reg_wr = 1'b1;
      bus_addr = 24'h004000; bus_kind = 2'b01; bus_dma = 1'b0; bus_valid = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; bus_valid = 1'b0;
      chk("R9 hit wins over clear", {31'b0, flag_o[0]}, 32'h1);
      wreg(2'd0, cbyte(1'b0, 3'd0, 2'b01, 1'b0));
      chk("R9 qualifier used up", {31'b0, flag_o[0]}, 32'h1);
      clear_ch(0);
      chk("R8 clear after fresh read", {31'b0, flag_o[0]}, 32'h0);
   endtask

   task automatic t_channels();
      logic [31:0] v;
      wreg(2'd1, 32'h00005000);
      wreg(2'd0, cbyte(1'b0, 3'd0, 2'b00, 1'b0));
      wreg(2'd3, 32'h00006000);
      wreg(2'd2, cbyte(1'b0, 3'd0, 2'b00, 1'b1));
      rreg(2'd1, v);
      chk("R11 channel A address untouched", v, 32'h00005000);
      bus(24'h005000, 2'b00, 1'b0);
      chk("R11 only A hits", {30'b0, flag_o}, 32'h1);
      chk("R10 A flag without ie no irq", {31'b0, irq_o}, 32'h0);
      bus(24'h006000, 2'b00, 1'b0);
      chk("R11 B hits", {30'b0, flag_o}, 32'h3);
      chk("R10 B raises irq", {31'b0, irq_o}, 32'h1);
      clear_ch(1);
      chk("R11 clearing B leaves A", {30'b0, flag_o}, 32'h1);
      clear_ch(0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_regmap();
      t_mask();
      t_cycle();
      t_master();
      t_flag();
      t_priority();
      t_channels();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      #(20 * 100000);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule